// File: doc/BRIEF.md
# Phase Transient Monitor and Trigger

This block watches a stream of signed phase-error samples, each giving the offset between the chosen input reference and the loop output. It does two things. First, it raises a sticky alarm when the size of the error goes above a programmable limit. If interrupts are enabled, the alarm also requests an interrupt. Second, it decides when a sudden input phase step is large enough that the loop should absorb it as a phase build-out. When that happens it sends a one-cycle trigger to the loop.

Triggering works in two stages. A coarse slope detector compares the phase every `SLOPE_TICKS` samples, which stands for a 10 ms span. When that short-term change exceeds `SLOPE_NS` (100 ns), the detector opens a qualification window of `WIN_TICKS` samples, which stands for 0.1 s. Inside the window, the phase is measured against the value it had before the step. A trigger is issued only if that total change goes beyond the programmed limit. The automatic triggering can be switched off, and a freeze control suppresses all build-out activity.

Samples are signed 32-bit values in units of 1 ns, each qualified by a valid strobe. The limit is a 12-bit count of nanoseconds. This covers the intended span of about 1000 to 3500 ns, and any value in between can be chosen.

Top module: `phase_xient_mon`

## Requirements
- R1: While `mon_en` is 0, `alarm_sts` cannot go from 0 to 1 and `bo_trig` stays 0. Any slope interval or open window is discarded, and the first valid sample after the enable is set again becomes the new interval start.
- R2: A valid sample with `mon_en`=1 whose magnitude |phase| is strictly greater than `limit_ns` sets `alarm_sts` in the cycle after that sample. A magnitude equal to the limit does not set it.
- R3: `alarm_sts` stays set after the error falls back below the limit. A one-cycle `alarm_clr`=1 clears it. If a sample sets the alarm in the same cycle as a clear, the set wins.
- R4: `irq` equals `alarm_sts` AND `irq_en`, with no added cycle of delay.
- R5: The slope detector takes the first valid sample as the interval start. It compares every `SLOPE_TICKS`-th valid sample after that against the start value. A difference whose magnitude is strictly greater than `SLOPE_NS` is a slope event. The compared sample then becomes the next interval start.
- R6: A slope event arms a window, provided `bo_en`=1, `mon_en`=1, `bo_freeze`=0 and no window is already open. The reference for the window is the start value of the interval that armed it. On each of the next `WIN_TICKS` valid samples, a magnitude |phase − reference| strictly greater than `limit_ns` causes `bo_trig` to pulse in the cycle after that sample.
- R7: `bo_trig` is high for exactly one cycle, and an armed window issues at most one trigger. Slope events that occur while a window is open are ignored.
- R8: A window that expires without exceeding the limit returns to idle. Only a new slope event arms it again, so a slow drift that never changes by more than `SLOPE_NS` per interval cannot trigger.
- R9: While `bo_freeze`=1, `bo_trig` stays 0, an open window is dropped, and slope events do not arm. Removing the freeze does not revive a step that was ignored.
- R10: With `bo_en`=0, no window is armed and `bo_trig` stays 0, but the alarm of R2 still works.
- R11: `limit_ns` applies at run time to both the alarm and the window test. The window test uses the limit value present at each sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | Phase sample valid strobe (one sample tick) |
| smp_phase | input | 32 | Signed phase error in ns |
| mon_en | input | 1 | Monitor enable |
| bo_en | input | 1 | Automatic build-out on transient enable |
| bo_freeze | input | 1 | Freeze build-out; suppresses triggers |
| irq_en | input | 1 | Interrupt enable for the alarm |
| limit_ns | input | 12 | Phase limit in ns |
| alarm_clr | input | 1 | Write-one-to-clear strobe for the alarm |
| alarm_sts | output | 1 | Sticky phase alarm status |
| irq | output | 1 | Interrupt request |
| bo_trig | output | 1 | One-cycle build-out trigger |

## Verification
`alarm_sts` and `bo_trig` are both registered. Each is due in the clock after the edge that takes the qualifying sample. `irq` follows `alarm_sts` combinationally, in the same cycle. The bench drives each sample just after a rising edge and does its directed checks one time step after the next edge, by which point that sample's results have settled. A behavioural model written with integers is updated at every rising edge and compared with all three outputs at the falling edge. Directed trigger counts fix the expected number of pulses for each scenario: step, small step, drift, freeze, disabled build-out and changed limit.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

  typedef enum logic [1:0] {
    WIN_IDLE  = 2'd0,
    WIN_ARMED = 2'd1,
    WIN_SPENT = 2'd2
  } win_state_e;

endpackage

// File: rtl/ptm_alarm.sv
module ptm_alarm #(
  parameter int SMP_W = 32,
  parameter int LIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             vld,
  input  logic [SMP_W-1:0] ph,
  input  logic [LIM_W-1:0] limit,
  input  logic             clr,
  input  logic             irq_en,
  output logic             alarm_sts,
  output logic             irq
);

  localparam int DW = SMP_W + 1;

  logic signed [DW-1:0] ph_ext;
  logic        [DW-1:0] mag;
  logic        [DW-1:0] lim_ext;
  logic                 over;
  logic                 alarm_q;
  logic                 alarm_d;

  always_comb begin
    ph_ext  = $signed({ph[SMP_W-1], ph});
    mag     = ph_ext[DW-1] ? $unsigned(-ph_ext) : $unsigned(ph_ext);
    lim_ext = {{(DW-LIM_W){1'b0}}, limit};
    over    = en && vld && (mag > lim_ext);
    alarm_d = over || (alarm_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= 1'b0;
    else        alarm_q <= alarm_d;
  end

  assign alarm_sts = alarm_q;
  assign irq       = alarm_q & irq_en;

  AST_ALARM_SETS:    assert property (@(posedge clk) disable iff (!rst_n)
                       over |=> alarm_sts); // R2
  AST_ALARM_STICKY:  assert property (@(posedge clk) disable iff (!rst_n)
                       (alarm_sts && !clr) |=> alarm_sts); // R3
  AST_ALARM_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n)
                       (clr && !(en && vld)) |=> !alarm_sts); // R3
  AST_ALARM_OFF:     assert property (@(posedge clk) disable iff (!rst_n)
                       (!en && !alarm_sts) |=> !alarm_sts); // R1

endmodule

// File: rtl/ptm_slope_det.sv
module ptm_slope_det #(
  parameter int SMP_W       = 32,
  parameter int SLOPE_TICKS = 10,
  parameter int SLOPE_NS    = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             vld,
  input  logic [SMP_W-1:0] ph,
  output logic             slope_evt,
  output logic [SMP_W-1:0] start_ph
);

  localparam int DW    = SMP_W + 1;
  localparam int CNT_W = (SLOPE_TICKS > 2) ? $clog2(SLOPE_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOPE_TICKS - 1);

  logic [SMP_W-1:0]     base_q, base_d;
  logic                 bvld_q, bvld_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic signed [DW-1:0] diff;
  logic        [DW-1:0] mag;
  logic                 at_end;

  always_comb begin
    diff      = $signed({ph[SMP_W-1], ph}) - $signed({base_q[SMP_W-1], base_q});
    mag       = diff[DW-1] ? $unsigned(-diff) : $unsigned(diff);
    at_end    = bvld_q && (cnt_q == CNT_LAST);
    slope_evt = en && vld && at_end && (mag > DW'(SLOPE_NS));
  end

  always_comb begin
    base_d = base_q;
    bvld_d = bvld_q;
    cnt_d  = cnt_q;
    if (!en) begin
      bvld_d = 1'b0;
      cnt_d  = '0;
    end else if (vld) begin
      if (!bvld_q || at_end) begin
        base_d = ph;
        bvld_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      bvld_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      bvld_q <= bvld_d;
      cnt_q  <= cnt_d;
    end
  end

  assign start_ph = base_q;

  AST_SLOPE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                      slope_evt |=> !slope_evt); // R5
  AST_SLOPE_REBASE: assert property (@(posedge clk) disable iff (!rst_n)
                      slope_evt |=> (start_ph == $past(ph))); // R5

endmodule

// File: rtl/ptm_bo_window.sv
module ptm_bo_window
  import ptm_pkg::*;
#(
  parameter int SMP_W     = 32,
  parameter int LIM_W     = 12,
  parameter int WIN_TICKS = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bo_en,
  input  logic             freeze,
  input  logic             vld,
  input  logic [SMP_W-1:0] ph,
  input  logic             slope_evt,
  input  logic [SMP_W-1:0] arm_ref,
  input  logic [LIM_W-1:0] limit,
  output logic             bo_trig
);

  localparam int DW    = SMP_W + 1;
  localparam int WCN_W = (WIN_TICKS > 2) ? $clog2(WIN_TICKS) : 1;
  localparam logic [WCN_W-1:0] WCN_LAST = WCN_W'(WIN_TICKS - 1);

  win_state_e           st_q, st_d;
  logic [SMP_W-1:0]     ref_q, ref_d;
  logic [WCN_W-1:0]     wcnt_q, wcnt_d;
  logic                 trig_q, trig_d;
  logic signed [DW-1:0] diff;
  logic        [DW-1:0] mag;
  logic                 exceed;
  logic                 last;

  always_comb begin
    diff   = $signed({ph[SMP_W-1], ph}) - $signed({ref_q[SMP_W-1], ref_q});
    mag    = diff[DW-1] ? $unsigned(-diff) : $unsigned(diff);
    exceed = mag > {{(DW-LIM_W){1'b0}}, limit};
    last   = (wcnt_q == WCN_LAST);
  end

  always_comb begin
    st_d   = st_q;
    ref_d  = ref_q;
    wcnt_d = wcnt_q;
    trig_d = 1'b0;
    if (!en || !bo_en || freeze) begin
      st_d   = WIN_IDLE;
      wcnt_d = '0;
    end else begin
      case (st_q)
        WIN_IDLE: begin
          if (slope_evt) begin
            st_d   = WIN_ARMED;
            ref_d  = arm_ref;
            wcnt_d = '0;
          end
        end
        WIN_ARMED: begin
          if (vld) begin
            trig_d = exceed;
            wcnt_d = wcnt_q + 1'b1;
            if (last)        st_d = WIN_IDLE;
            else if (exceed) st_d = WIN_SPENT;
          end
        end
        WIN_SPENT: begin
          if (vld) begin
            wcnt_d = wcnt_q + 1'b1;
            if (last) st_d = WIN_IDLE;
          end
        end
        default: st_d = WIN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WIN_IDLE;
      ref_q  <= '0;
      wcnt_q <= '0;
      trig_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ref_q  <= ref_d;
      wcnt_q <= wcnt_d;
      trig_q <= trig_d;
    end
  end

  assign bo_trig = trig_q;

  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                        bo_trig |=> !bo_trig); // R7
  AST_TRIG_SPENDS:    assert property (@(posedge clk) disable iff (!rst_n)
                        bo_trig |-> (st_q != WIN_ARMED)); // R7
  AST_FREEZE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n)
                        freeze |=> !bo_trig); // R9
  AST_BOEN_QUIET:     assert property (@(posedge clk) disable iff (!rst_n)
                        !bo_en |=> !bo_trig); // R10
  AST_MON_OFF_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
                        !en |=> (!bo_trig && st_q == WIN_IDLE)); // R1

endmodule

// File: rtl/phase_xient_mon.sv
module phase_xient_mon #(
  parameter int SMP_W       = 32,
  parameter int LIM_W       = 12,
  parameter int SLOPE_TICKS = 10,
  parameter int SLOPE_NS    = 100,
  parameter int WIN_TICKS   = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp_phase,
  input  logic             mon_en,
  input  logic             bo_en,
  input  logic             bo_freeze,
  input  logic             irq_en,
  input  logic [LIM_W-1:0] limit_ns,
  input  logic             alarm_clr,
  output logic             alarm_sts,
  output logic             irq,
  output logic             bo_trig
);

  logic             rst_meta_q;
  logic             rst_sync_n;
  logic             slope_evt;
  logic [SMP_W-1:0] start_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ptm_alarm #(.SMP_W(SMP_W), .LIM_W(LIM_W)) u_alarm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (mon_en),
    .vld       (smp_vld),
    .ph        (smp_phase),
    .limit     (limit_ns),
    .clr       (alarm_clr),
    .irq_en    (irq_en),
    .alarm_sts (alarm_sts),
    .irq       (irq)
  );

  ptm_slope_det #(.SMP_W(SMP_W), .SLOPE_TICKS(SLOPE_TICKS), .SLOPE_NS(SLOPE_NS)) u_slope (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (mon_en),
    .vld       (smp_vld),
    .ph        (smp_phase),
    .slope_evt (slope_evt),
    .start_ph  (start_ph)
  );

  ptm_bo_window #(.SMP_W(SMP_W), .LIM_W(LIM_W), .WIN_TICKS(WIN_TICKS)) u_win (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (mon_en),
    .bo_en     (bo_en),
    .freeze    (bo_freeze),
    .vld       (smp_vld),
    .ph        (smp_phase),
    .slope_evt (slope_evt),
    .arm_ref   (start_ph),
    .limit     (limit_ns),
    .bo_trig   (bo_trig)
  );

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
                   (irq == (alarm_sts && irq_en))); // R4

endmodule

// File: tb/tb_phase_xient_mon.sv
module tb_phase_xient_mon;

  localparam int CLK_P = 10;
  localparam int ST    = 10;
  localparam int WT    = 100;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_vld = 1'b0;
  logic signed [31:0] smp_phase = '0;
  logic               mon_en = 1'b0;
  logic               bo_en = 1'b0;
  logic               bo_freeze = 1'b0;
  logic               irq_en = 1'b0;
  logic [11:0]        limit_ns = 12'd1000;
  logic               alarm_clr = 1'b0;
  logic               alarm_sts, irq, bo_trig;

  int errors = 0;
  int checks = 0;
  int trig_cnt = 0;
  bit running = 0;

  always #(CLK_P/2) clk = ~clk;

  phase_xient_mon dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_phase(smp_phase),
    .mon_en(mon_en), .bo_en(bo_en), .bo_freeze(bo_freeze), .irq_en(irq_en),
    .limit_ns(limit_ns), .alarm_clr(alarm_clr),
    .alarm_sts(alarm_sts), .irq(irq), .bo_trig(bo_trig)
  );

  function automatic longint labs(input longint x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic chk(input longint act, input longint exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit     m_alarm, m_bvld, m_trig, m_evt;
  int     m_cnt, m_st, m_wcnt;
  longint m_base, m_ref, m_armref;

  always @(posedge clk) begin
    if (!running) begin
      m_alarm = 0; m_bvld = 0; m_trig = 0; m_cnt = 0; m_st = 0; m_wcnt = 0;
      m_base = 0; m_ref = 0;
    end else begin
      longint p;
      p = longint'(smp_phase);
      m_alarm = (mon_en && smp_vld && labs(p) > longint'(limit_ns)) || (m_alarm && !alarm_clr);
      m_evt = 0;
      if (!mon_en) begin
        m_bvld = 0; m_cnt = 0;
      end else if (smp_vld) begin
        if (!m_bvld) begin
          m_base = p; m_bvld = 1; m_cnt = 0;
        end else if (m_cnt == ST - 1) begin
          m_evt = labs(p - m_base) > 100;
          m_armref = m_base; m_base = p; m_cnt = 0;
        end else m_cnt++;
      end
      m_trig = 0;
      if (!mon_en || !bo_en || bo_freeze) begin
        m_st = 0; m_wcnt = 0;
      end else if (m_st == 0) begin
        if (m_evt) begin m_st = 1; m_ref = m_armref; m_wcnt = 0; end
      end else if (smp_vld) begin
        if (m_st == 1 && labs(p - m_ref) > longint'(limit_ns)) begin
          m_trig = 1; m_st = 2;
        end
        m_wcnt++;
        if (m_wcnt == WT) m_st = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk(alarm_sts, m_alarm, "R2/R3 model alarm_sts");
      chk(irq, m_alarm && irq_en, "R4 model irq");
      chk(bo_trig, m_trig, "R6/R7 model bo_trig");
      if (bo_trig) trig_cnt++;
    end
  end

  task automatic smp(input longint p);
    smp_vld = 1'b1;
    smp_phase = 32'(p);
    @(posedge clk); #1;
  endtask

  task automatic hold(input longint p, input int n);
    for (int i = 0; i < n; i++) smp(p);
  endtask

  task automatic restart(input longint p);
    mon_en = 1'b0; smp(p); mon_en = 1'b1; hold(p, 12);
    trig_cnt = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(alarm_sts, 0, "reset alarm_sts");
    chk(irq, 0, "reset irq");
    chk(bo_trig, 0, "reset bo_trig");
    running = 1;

    // R1: monitor disabled
    bo_en = 1; irq_en = 1;
    hold(0, 12); hold(5000, 30); hold(-5000, 30);
    chk(alarm_sts, 0, "R1 alarm while disabled");
    chk(trig_cnt, 0, "R1 triggers while disabled");

    // R2 boundary, R4 gating
    bo_en = 0; irq_en = 0;
    restart(0);
    smp(1000);
    chk(alarm_sts, 0, "R2 equal to limit");
    smp(1001);
    chk(alarm_sts, 1, "R2 above limit");
    chk(irq, 0, "R4 irq masked");
    irq_en = 1; #1;
    chk(irq, 1, "R4 irq enabled");
    // R3 sticky and clear
    hold(0, 5);
    chk(alarm_sts, 1, "R3 sticky");
    alarm_clr = 1; smp(0); alarm_clr = 0;
    chk(alarm_sts, 0, "R3 cleared");
    alarm_clr = 1; smp(-1500); alarm_clr = 0;
    chk(alarm_sts, 1, "R3 set wins over clear");
    alarm_clr = 1; smp(0); alarm_clr = 0;
    chk(alarm_sts, 0, "R3 cleared again");

    // R5/R6/R7: step transient
    bo_en = 1;
    restart(0);
    hold(1500, 11);
    chk(trig_cnt, 1, "R5 trigger within one slope interval");
    hold(1500, 120);
    chk(trig_cnt, 1, "R7 single trigger per window");

    // R8: small step then slow drift
    restart(0);
    hold(200, 120);
    chk(trig_cnt, 0, "R8 small step no trigger");
    for (int i = 1; i <= 150; i++) smp(200 + 10 * i);
    chk(trig_cnt, 0, "R8 drift no rearm");

    // R9: freeze
    restart(0);
    bo_freeze = 1;
    hold(1500, 30);
    chk(trig_cnt, 0, "R9 frozen step");
    bo_freeze = 0;
    hold(1500, 30);
    chk(trig_cnt, 0, "R9 ignored step after unfreeze");

    // R10: build-out disabled
    restart(0);
    bo_en = 0;
    hold(-1500, 30);
    chk(trig_cnt, 0, "R10 no trigger with bo_en=0");
    chk(alarm_sts, 1, "R10 alarm still works");
    bo_en = 1;

    // R11: raised limit
    limit_ns = 12'd3000;
    restart(0);
    hold(-2000, 15);
    chk(trig_cnt, 0, "R11 below raised limit");
    hold(-3500, 3);
    chk(trig_cnt, 1, "R11 above raised limit");
    hold(-7000, 20);
    chk(trig_cnt, 1, "R7 no second trigger");
    hold(-7000, 100);

    smp_vld = 0;
    repeat (3) @(posedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule